// File: doc/BRIEF.md
# Keyboard and Display Interrupt Port

This block attaches one character source (a keyboard encoder) and one character sink (a display) to a simple processor bus. The processor reaches four byte registers through a two-bit offset: the received character, the character to show, a read-only status byte and a read/write control byte. A received character raises an input-ready flag. An output-ready flag shows that the display can take another character.

Each direction has an interrupt enable in the control byte and a pending flag in the status byte. The two pending flags are ORed into one active-high interrupt request. Software can poll the ready flags, or it can enable interrupts and service whichever side is pending. A typical use reads characters until a carriage return (0x0D) arrives and echoes each one, then sends a line feed (0x0A).

A sticky overrun flag records that a character arrived while the previous one was still unread. Reading the status byte clears it.

Top module: `kbd_disp_port`

## Requirements
- R1: A synchronous active-high reset clears both enables, the input-ready flag, the overrun flag and both data registers, and sets the output-ready flag. Status then reads 0x02, control reads 0x00 and irq is low.
- R2: When kb_valid is high at a clock edge, kb_data is captured into the receive register (offset 0) and status bit 0 (input ready) becomes 1.
- R3: A read of offset 0 clears input ready after that edge. If kb_valid is high in the same cycle, the new character is loaded and input ready stays 1.
- R4: A write to offset 1 stores the byte on dp_data and clears status bit 1 (output ready). dp_valid is high exactly while output ready is 0.
- R5: dp_taken high at an edge sets output ready. If a write to offset 1 happens in the same cycle, the write wins and output ready becomes 0.
- R6: Control (offset 3) holds the keyboard enable in bit 2 and the display enable in bit 3. Its other bits read 0 and a write to them has no effect.
- R7: Status bit 2 reads input ready AND keyboard enable. Status bit 3 reads output ready AND display enable.
- R8: irq is high exactly when status bit 2 or status bit 3 is 1.
- R9: Status bit 4 (overrun) becomes 1 when kb_valid arrives while input ready is 1 and offset 0 is not being read. A read of offset 2 clears it, but a new overrun in the same cycle wins.
- R10: Writes to offsets 0 and 2 change nothing. bus_rdata is 0 whenever no read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from offset and state |
| kb_valid | input | 1 | New keyboard character present |
| kb_data | input | DW | Keyboard character |
| dp_data | output | DW | Character held for the display |
| dp_valid | output | 1 | Character waiting for the display |
| dp_taken | input | 1 | Display has taken the character |
| irq | output | 1 | Combined interrupt request, active high |

## Verification
The bench builds the port with its default 8-bit data width. At that width every character value can be driven, including carriage return and line feed, and every status and control bit position can be checked against bus reads. Random traffic creates collisions by chance: arrivals during reads, writes during display handshakes, and status reads during overruns. Directed sequences also force each of these collisions at least once.

// File: rtl/kbd_disp_port.sv
module kbd_disp_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          kb_valid,
  input  logic [DW-1:0] kb_data,
  output logic [DW-1:0] dp_data,
  output logic          dp_valid,
  input  logic          dp_taken,
  output logic          irq
);
  localparam logic [1:0] OFS_RX = 2'd0;
  localparam logic [1:0] OFS_TX = 2'd1;
  localparam logic [1:0] OFS_ST = 2'd2;
  localparam logic [1:0] OFS_CT = 2'd3;
  localparam int KEN_B = 2;
  localparam int DEN_B = 3;

  logic [DW-1:0] rx_q, tx_q;
  logic sin_q, sout_q, ken_q, den_q, ovr_q;
  logic rd, rd_rx, rd_st, wr_tx, wr_ct, kirq, dirq, unused_wd;

  assign rd    = bus_sel & ~bus_we;
  assign rd_rx = rd && bus_addr == OFS_RX;
  assign rd_st = rd && bus_addr == OFS_ST;
  assign wr_tx = bus_sel && bus_we && bus_addr == OFS_TX;
  assign wr_ct = bus_sel && bus_we && bus_addr == OFS_CT;
  assign kirq  = sin_q & ken_q;
  assign dirq  = sout_q & den_q;
  assign irq   = kirq | dirq;
  assign dp_data  = tx_q;
  assign dp_valid = ~sout_q;
  assign unused_wd = ^{bus_wdata[DW-1:DEN_B+1], bus_wdata[KEN_B-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q <= '0; tx_q <= '0;
      sin_q <= 1'b0; sout_q <= 1'b1;
      ken_q <= 1'b0; den_q <= 1'b0; ovr_q <= 1'b0;
    end else begin
      if (kb_valid) begin
        rx_q  <= kb_data;
        sin_q <= 1'b1;
      end else if (rd_rx) begin
        sin_q <= 1'b0;
      end
      if (kb_valid && sin_q && !rd_rx) ovr_q <= 1'b1;
      else if (rd_st)                  ovr_q <= 1'b0;
      if (wr_tx) begin
        tx_q   <= bus_wdata;
        sout_q <= 1'b0;
      end else if (dp_taken) begin
        sout_q <= 1'b1;
      end
      if (wr_ct) begin
        ken_q <= bus_wdata[KEN_B];
        den_q <= bus_wdata[DEN_B];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        OFS_RX:  bus_rdata = rx_q;
        OFS_TX:  bus_rdata = tx_q;
        OFS_ST:  bus_rdata = DW'({ovr_q, dirq, kirq, sout_q, sin_q});
        default: bus_rdata = DW'({den_q, ken_q, 2'b00});
      endcase
    end
  end
endmodule

module kdp_checker (
  input logic clk,
  input logic rst,
  input logic sel,
  input logic we,
  input logic [1:0] addr,
  input logic kb_valid,
  input logic dp_taken,
  input logic sin,
  input logic sout,
  input logic ken,
  input logic den,
  input logic ovr,
  input logic irq,
  input logic dp_valid
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (sout && !sin && !ken && !den && !ovr)); // R1
  AST_SIN_SET: assert property (@(posedge clk) disable iff (rst) kb_valid |=> sin); // R2
  AST_RX_READ_CLR: assert property (@(posedge clk) disable iff (rst)
    (sel && !we && addr == 2'd0 && !kb_valid) |=> !sin); // R3
  AST_TX_WRITE_CLR: assert property (@(posedge clk) disable iff (rst)
    (sel && we && addr == 2'd1) |=> (!sout && dp_valid)); // R4
  AST_TAKEN_SET: assert property (@(posedge clk) disable iff (rst)
    (dp_taken && !(sel && we && addr == 2'd1)) |=> sout); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst) (!ken && !den) |-> !irq); // R8
  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    (kb_valid && sin && !(sel && !we && addr == 2'd0)) |=> ovr); // R9
endmodule

bind kbd_disp_port kdp_checker u_chk (
  .clk(clk), .rst(rst), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
  .kb_valid(kb_valid), .dp_taken(dp_taken), .sin(sin_q), .sout(sout_q),
  .ken(ken_q), .den(den_q), .ovr(ovr_q), .irq(irq), .dp_valid(dp_valid)
);

// File: tb/kbd_disp_port_tb.sv
module kbd_disp_port_tb;
  localparam int CLK_P = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 0, bus_we = 0, kb_valid = 0, dp_taken = 0;
  logic [1:0] bus_addr = 0;
  logic [DW-1:0] bus_wdata = 0, kb_data = 0;
  logic [DW-1:0] bus_rdata, dp_data;
  logic dp_valid, irq;

  int n_chk = 0, n_bad = 0;
  logic done = 0;

  logic [DW-1:0] m_rx, m_tx;
  logic m_sin, m_sout, m_ken, m_den, m_ovr;

  always #(CLK_P/2) clk = ~clk;

  kbd_disp_port #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kb_valid(kb_valid), .kb_data(kb_data),
    .dp_data(dp_data), .dp_valid(dp_valid), .dp_taken(dp_taken), .irq(irq)
  );

  function automatic logic [DW-1:0] exp_rd(input logic s, input logic w, input logic [1:0] a);
    if (!s || w) return '0;
    case (a)
      2'd0: return m_rx;
      2'd1: return m_tx;
      2'd2: return DW'({m_ovr, m_sout & m_den, m_sin & m_ken, m_sout, m_sin});
      default: return DW'({m_den, m_ken, 2'b00});
    endcase
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_rx = 0; m_tx = 0; m_sin = 0; m_sout = 1; m_ken = 0; m_den = 0; m_ovr = 0;
  endtask

  task automatic cyc(input logic s, input logic w, input logic [1:0] a, input logic [DW-1:0] wd,
                     input logic kv, input logic [DW-1:0] kd, input logic tk, input string tag);
    logic rdrx, rdst, wrtx;
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = wd;
    kb_valid = kv; kb_data = kd; dp_taken = tk;
    #1;
    chk({tag, " rdata R10"}, bus_rdata, exp_rd(s, w, a));
    chk("R8 irq", DW'(irq), DW'((m_sin & m_ken) | (m_sout & m_den)));
    chk("R4 dp_valid", DW'(dp_valid), DW'(!m_sout));
    chk("R4 dp_data", dp_data, m_tx);
    @(posedge clk);
    rdrx = s && !w && a == 2'd0;
    rdst = s && !w && a == 2'd2;
    wrtx = s && w && a == 2'd1;
    if (kv && m_sin && !rdrx) m_ovr = 1; else if (rdst) m_ovr = 0;
    if (kv) begin m_rx = kd; m_sin = 1; end else if (rdrx) m_sin = 0;
    if (wrtx) begin m_tx = wd; m_sout = 0; end else if (tk) m_sout = 1;
    if (s && w && a == 2'd3) begin m_ken = wd[2]; m_den = wd[3]; end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (2) @(negedge clk);
    rst = 0;
    // R1 reset state
    cyc(1, 0, 2'd2, 0, 0, 0, 0, "R1 status");
    cyc(1, 0, 2'd3, 0, 0, 0, 0, "R1 control");
    // R2 arrival, R3 read clears
    cyc(0, 0, 0, 0, 1, 8'h0D, 0, "R2 arrive");
    cyc(1, 0, 2'd2, 0, 0, 0, 0, "R2 sin set");
    cyc(1, 0, 2'd0, 0, 0, 0, 0, "R3 read char");
    cyc(1, 0, 2'd2, 0, 0, 0, 0, "R3 sin clear");
    // R3 read with simultaneous arrival
    cyc(0, 0, 0, 0, 1, 8'h41, 0, "R2 arrive");
    cyc(1, 0, 2'd0, 0, 1, 8'h42, 0, "R3 read+arrive");
    cyc(1, 0, 2'd2, 0, 0, 0, 0, "R3 sin kept no ovr");
    // R9 overrun, then status read clears, set wins
    cyc(0, 0, 0, 0, 1, 8'h43, 0, "R9 overrun");
    cyc(1, 0, 2'd2, 0, 0, 0, 0, "R9 ovr set");
    cyc(1, 0, 2'd2, 0, 0, 0, 0, "R9 ovr cleared");
    cyc(1, 0, 2'd2, 0, 1, 8'h44, 0, "R9 read+overrun");
    cyc(1, 0, 2'd2, 0, 0, 0, 0, "R9 set wins");
    // R4 write, R5 taken, collision
    cyc(1, 1, 2'd1, 8'h0A, 0, 0, 0, "R4 write tx");
    cyc(1, 0, 2'd2, 0, 0, 0, 0, "R4 sout clear");
    cyc(0, 0, 0, 0, 0, 0, 1, "R5 taken");
    cyc(1, 0, 2'd2, 0, 0, 0, 0, "R5 sout set");
    cyc(1, 1, 2'd1, 8'h55, 0, 0, 1, "R5 write+taken");
    cyc(1, 0, 2'd2, 0, 0, 0, 0, "R5 write wins");
    // R6 R7 R8 enables
    cyc(1, 1, 2'd3, 8'hFF, 0, 0, 0, "R6 ctrl write");
    cyc(1, 0, 2'd3, 0, 0, 0, 0, "R6 ctrl readback");
    cyc(1, 0, 2'd2, 0, 0, 0, 0, "R7 pending");
    cyc(0, 0, 0, 0, 0, 0, 1, "R7 taken");
    cyc(1, 0, 2'd2, 0, 0, 0, 0, "R7 dirq");
    cyc(1, 1, 2'd3, 8'hFB, 0, 0, 0, "R6 clear ken");
    cyc(1, 0, 2'd3, 0, 0, 0, 0, "R6 ken off");
    // R10 ignored writes
    cyc(1, 1, 2'd0, 8'hA5, 0, 0, 0, "R10 write rx");
    cyc(1, 1, 2'd2, 8'hFF, 0, 0, 0, "R10 write status");
    cyc(1, 0, 2'd0, 0, 0, 0, 0, "R10 rx unchanged");
    cyc(1, 0, 2'd2, 0, 0, 0, 0, "R10 status unchanged");
    // random mix covering R2 R3 R4 R5 R7 R9
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 2) == 0, ($urandom % 3) == 0, 2'($urandom), 8'($urandom),
          ($urandom % 10) < 3, 8'($urandom), ($urandom % 10) < 3, "R2/R3/R7/R9 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule